// File: doc/BRIEF.md
# Paged Memory Function-Command Sequencer

This block is the function-command layer of a small serial memory. A link layer below it delivers whole received bytes and asks for transmit bytes one at a time; the sequencer decodes the command byte that opens each transaction, collects address and data arguments, and streams back memory contents with CRC-8 protection. The memory is 5 pages of 32 bytes, held in an internal register array and written only through an 8-byte scratchpad. Per-page write-protect bits live in a status field and can only be cleared. A fixed busy interval stands in for the nonvolatile programming time.

Eight commands are decoded: F0h (legacy read with one trailing data CRC), C3h (legacy read with a CRC after every page), 65h (read of the whole array), AAh (status read), 6Ch (scratchpad write), 69h (scratchpad read), 48h (scratchpad copy) and 55h (write-protect update). The link layer pulses `link_reset` when the bus master issues a bus reset, which ends any transaction that is still open.

The controller moves through these states: CMD (awaiting a command byte) goes to TA1 for the four reads and the copy, to WSP_OFS for 6Ch, to RSP_OFS for 69h, to WST for 55h, and to IGNORE for any other byte. TA1 goes to TA2. TA2 goes to PROG for a copy and to HDR otherwise. HDR sends the header CRC and goes to MEM, STAT or ONES. MEM and STAT go to DCRC at the end of their span. DCRC goes back to MEM at a page boundary of a C3h read and to ONES otherwise. WSP_OFS goes to WSP_DAT, RSP_OFS to RSP_DAT, WST to PROG, and PROG to IGNORE when the busy interval ends. A `link_reset` moves every state except PROG back to CMD.

Top module: `pagemem_cmdseq`

## Requirements
- R1: After reset every array byte reads FFh, all five write-protect bits are 1, status bytes 01h to 06h read FFh, status byte 07h reads 00h, `busy` is low and `tx_valid` is low.
- R2: Commands F0h, C3h, 65h and AAh take a low address byte then a high address byte and first return a CRC-8 over the command and both address bytes (polynomial x^8+x^5+x^4+1, bits taken LSB first, i.e. shift right and XOR 8Ch, initial value 00h); for F0h, C3h and AAh the 16-bit address is ANDed with 007Fh before it is used and before it enters the CRC.
- R3: F0h returns array bytes from the masked start through byte 7Fh, then one CRC of those data bytes (restarted at 00h after the header CRC), then FFh for every further request.
- R4: C3h returns array bytes to the end of the current 32-byte page, then a CRC of the bytes read in that page, restarts the CRC and continues with the next page; after the CRC of the page ending at 7Fh it returns FFh.
- R5: 65h returns array bytes from the unmasked start through 9Fh, then a CRC of those bytes, then FFh; a start address of A0h or above returns FFh straight after the header CRC.
- R6: 6Ch takes a one-byte offset and then stores each following byte at the offset, which advances by one per byte; bytes arriving while the offset is above 07h are dropped and scratchpad bytes not written keep their value.
- R7: 69h takes a one-byte offset and returns scratchpad bytes from it, advancing by one; with the offset above 07h it returns FFh.
- R8: 48h takes a low then a high address byte, clears the three low address bits, raises `busy` in the cycle after the high byte is received, holds it for PROG_CYCLES cycles, and writes all 8 scratchpad bytes to the aligned location at the end of that interval.
- R9: Status byte 00h holds the write-protect bit of page p at bit p (bits 5 to 7 read 1); 55h takes one byte, runs the same busy interval, and at its end ANDs bits 0 to 4 of that byte into the write-protect bits, so a bit can go to 0 but never back to 1.
- R10: A copy whose aligned address is A0h or above, or whose page has its write-protect bit at 0, leaves the array unchanged while the busy interval still runs.
- R11: AAh returns status bytes from the masked start through byte 07h, then a CRC of those bytes, then FFh; a masked start of 08h or above returns FFh straight after the header CRC.
- R12: Each one-cycle `tx_req` pulse gives a one-cycle `tx_valid` pulse with the byte in `tx_data` one cycle later, and `tx_valid` never rises without a request; a request while the command has nothing to send returns FFh.
- R13: `link_reset` abandons an unfinished command and returns to awaiting a command byte, except during the busy interval, where it and received bytes are ignored; an unknown command byte makes every later byte be ignored until the next `link_reset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_reset | input | 1 | One-cycle pulse: bus reset seen by the link layer |
| rx_valid | input | 1 | One-cycle pulse: a whole byte was received |
| rx_data | input | 8 | Received byte, valid with rx_valid |
| tx_req | input | 1 | One-cycle pulse: link layer wants the next byte to send |
| tx_valid | output | 1 | One-cycle pulse one cycle after tx_req |
| tx_data | output | 8 | Byte to transmit, valid with tx_valid |
| busy | output | 1 | High during the programming interval |

## Verification
The assertions assume the link layer sends one-cycle pulses on `rx_valid` and `tx_req` and never raises both in the same cycle, so that a busy interval can only start from a received byte and every transmit pulse maps to exactly one request. The bench drives each pulse from one falling edge to the next with idle cycles between them and never overlaps a request with a received byte. It also relies on the write-protect bits only ever changing on the cycle the busy interval ends, which the bench keeps true by waiting for `busy` to fall before opening the next transaction.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_TA1,
        ST_TA2,
        ST_HDR,
        ST_MEM,
        ST_DCRC,
        ST_STAT,
        ST_ONES,
        ST_WSP_OFS,
        ST_WSP_DAT,
        ST_RSP_OFS,
        ST_RSP_DAT,
        ST_WST,
        ST_PROG,
        ST_IGNORE
    } seq_state_t;

    localparam logic [7:0] CMD_RD_LEGACY = 8'hF0;
    localparam logic [7:0] CMD_RD_PAGED  = 8'hC3;
    localparam logic [7:0] CMD_RD_ALL    = 8'h65;
    localparam logic [7:0] CMD_RD_STAT   = 8'hAA;
    localparam logic [7:0] CMD_WR_SP     = 8'h6C;
    localparam logic [7:0] CMD_RD_SP     = 8'h69;
    localparam logic [7:0] CMD_COPY_SP   = 8'h48;
    localparam logic [7:0] CMD_WR_STAT   = 8'h55;

    // One byte through the reflected CRC-8 (x^8+x^5+x^4+1), LSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sq_crc8.sv
module sq_crc8
    import sq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    logic [7:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= 8'h00;
        else if (clr) crc_q <= 8'h00;
        else if (upd) crc_q <= crc8_step(crc_q, din);
    end

    assign crc = crc_q;

endmodule

// File: rtl/sq_busy_timer.sv
module sq_busy_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    assign busy = run_q;
    assign done = run_q && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start && !run_q) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sq_store.sv
module sq_store #(
    parameter int PAGES      = 5,
    parameter int PAGE_BYTES = 32,
    parameter int SP_BYTES   = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]    rd_idx,
    output logic [7:0]                             rd_byte,
    input  logic                                   sp_we,
    input  logic [$clog2(SP_BYTES)-1:0]            sp_idx,
    input  logic [7:0]                             sp_wbyte,
    output logic [7:0]                             sp_rbyte,
    input  logic                                   copy_go,
    input  logic [15:0]                            copy_addr,
    input  logic                                   wp_go,
    input  logic [PAGES-1:0]                       wp_mask,
    output logic [PAGES-1:0]                       wp
);

    localparam int MEM_BYTES = PAGES * PAGE_BYTES;
    localparam int MIDX_W    = $clog2(MEM_BYTES);
    localparam int SP_W      = $clog2(SP_BYTES);
    localparam int PG_SH     = $clog2(PAGE_BYTES);
    localparam logic [15:0] MEM_LIM = 16'(MEM_BYTES);

    logic [7:0]       mem  [MEM_BYTES];
    logic [7:0]       sp_q [SP_BYTES];
    logic [PAGES-1:0] wp_q;
    logic             page_open;
    logic             copy_ok;

    always_comb begin
        page_open = 1'b0;
        for (int p = 0; p < PAGES; p++) begin
            if ((copy_addr >> PG_SH) == 16'(p)) page_open = wp_q[p];
        end
    end

    assign copy_ok = copy_go && (copy_addr < MEM_LIM) && page_open;

    for (genvar b = 0; b < MEM_BYTES; b++) begin : g_cell
        localparam logic [MIDX_W-SP_W-1:0] BLK = (MIDX_W-SP_W)'(b / SP_BYTES);
        localparam int LANE = b % SP_BYTES;
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= 8'hFF;
            else if (copy_ok && (copy_addr[MIDX_W-1:SP_W] == BLK))
                cell_q <= sp_q[LANE];
        end
        assign mem[b] = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SP_BYTES; i++) sp_q[i] <= 8'hFF;
        end else if (sp_we) begin
            sp_q[sp_idx] <= sp_wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wp_q <= '1;
        else if (wp_go) wp_q <= wp_q & wp_mask;
    end

    assign rd_byte  = mem[rd_idx];
    assign sp_rbyte = sp_q[sp_idx];
    assign wp       = wp_q;

endmodule

// File: rtl/pagemem_cmdseq.sv
module pagemem_cmdseq
    import sq_pkg::*;
#(
    parameter int PAGES        = 5,
    parameter int PAGE_BYTES   = 32,
    parameter int LEGACY_PAGES = 4,
    parameter int SP_BYTES     = 8,
    parameter int STAT_BYTES   = 8,
    parameter int PROG_CYCLES  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       busy
);

    localparam int MEM_BYTES = PAGES * PAGE_BYTES;
    localparam int LEG_BYTES = LEGACY_PAGES * PAGE_BYTES;
    localparam int MIDX_W    = $clog2(MEM_BYTES);
    localparam int SP_W      = $clog2(SP_BYTES);
    localparam int PG_SH     = $clog2(PAGE_BYTES);
    localparam int SIDX_W    = $clog2(STAT_BYTES);
    localparam logic [15:0] MEM_LIM    = 16'(MEM_BYTES);
    localparam logic [15:0] MEM_LAST   = 16'(MEM_BYTES - 1);
    localparam logic [15:0] LEG_LIM    = 16'(LEG_BYTES);
    localparam logic [15:0] LEG_MASK   = 16'(LEG_BYTES - 1);
    localparam logic [15:0] STAT_LIM   = 16'(STAT_BYTES);
    localparam logic [15:0] STAT_LAST  = 16'(STAT_BYTES - 1);
    localparam logic [15:0] SP_LIM     = 16'(SP_BYTES);
    localparam logic [15:0] ALIGN_MASK = ~16'(SP_BYTES - 1);

    seq_state_t  state_q, state_d;
    logic [7:0]  cmd_q, cmd_d;
    logic [15:0] ptr_q, ptr_d;
    logic [7:0]  tx_data_q, tx_byte;

    logic        crc_clr, crc_upd;
    logic [7:0]  crc_din, crc_val;
    logic        sp_we, prog_start, prog_done, copy_go, wp_go;
    logic [7:0]  rd_byte, sp_rbyte, stat_byte, arg_byte;
    logic [PAGES-1:0] wp_bits;
    logic        legacy_cmd, span_end;

    sq_crc8 u_crc (
        .clk (clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
        .din (crc_din), .crc(crc_val)
    );

    sq_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk (clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(prog_done)
    );

    sq_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .SP_BYTES(SP_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ptr_q[MIDX_W-1:0]),
        .rd_byte  (rd_byte),
        .sp_we    (sp_we),
        .sp_idx   (ptr_q[SP_W-1:0]),
        .sp_wbyte (rx_data),
        .sp_rbyte (sp_rbyte),
        .copy_go  (copy_go),
        .copy_addr(ptr_q),
        .wp_go    (wp_go),
        .wp_mask  (ptr_q[PAGES-1:0]),
        .wp       (wp_bits)
    );

    assign legacy_cmd = (cmd_q == CMD_RD_LEGACY) || (cmd_q == CMD_RD_PAGED) ||
                        (cmd_q == CMD_RD_STAT);

    // Status field: protect bits in byte 0, fixed 00h at the top byte, FFh elsewhere.
    always_comb begin
        if (ptr_q[SIDX_W-1:0] == '0)
            stat_byte = {{(8-PAGES){1'b1}}, wp_bits};
        else if (ptr_q[SIDX_W-1:0] == STAT_LAST[SIDX_W-1:0])
            stat_byte = 8'h00;
        else
            stat_byte = 8'hFF;
    end

    always_comb begin
        unique case (cmd_q)
            CMD_RD_PAGED: span_end = &ptr_q[PG_SH-1:0];
            CMD_RD_ALL:   span_end = (ptr_q == MEM_LAST);
            default:      span_end = (ptr_q == LEG_MASK);
        endcase
    end

    // Next state and control strobes.
    always_comb begin
        state_d    = state_q;
        cmd_d      = cmd_q;
        ptr_d      = ptr_q;
        tx_byte    = 8'hFF;
        crc_clr    = 1'b0;
        crc_upd    = 1'b0;
        crc_din    = rx_data;
        sp_we      = 1'b0;
        prog_start = 1'b0;
        copy_go    = 1'b0;
        wp_go      = 1'b0;
        arg_byte   = rx_data;

        if (link_reset && state_q != ST_PROG) begin
            state_d = ST_CMD;
            crc_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_CMD: if (rx_valid) begin
                    cmd_d   = rx_data;
                    crc_upd = 1'b1;
                    unique case (rx_data)
                        CMD_RD_LEGACY, CMD_RD_PAGED, CMD_RD_ALL,
                        CMD_RD_STAT, CMD_COPY_SP:  state_d = ST_TA1;
                        CMD_WR_SP:                 state_d = ST_WSP_OFS;
                        CMD_RD_SP:                 state_d = ST_RSP_OFS;
                        CMD_WR_STAT:               state_d = ST_WST;
                        default:                   state_d = ST_IGNORE;
                    endcase
                end
                ST_TA1: if (rx_valid) begin
                    arg_byte   = legacy_cmd ? (rx_data & LEG_MASK[7:0]) : rx_data;
                    crc_din    = arg_byte;
                    crc_upd    = 1'b1;
                    ptr_d[7:0] = arg_byte;
                    state_d    = ST_TA2;
                end
                ST_TA2: if (rx_valid) begin
                    arg_byte    = legacy_cmd ? (rx_data & LEG_MASK[15:8]) : rx_data;
                    crc_din     = arg_byte;
                    crc_upd     = 1'b1;
                    ptr_d[15:8] = arg_byte;
                    if (cmd_q == CMD_COPY_SP) begin
                        ptr_d      = {arg_byte, ptr_q[7:0]} & ALIGN_MASK;
                        prog_start = 1'b1;
                        state_d    = ST_PROG;
                    end else begin
                        state_d = ST_HDR;
                    end
                end
                ST_HDR: if (tx_req) begin
                    tx_byte = crc_val;
                    crc_clr = 1'b1;
                    if (cmd_q == CMD_RD_STAT)
                        state_d = (ptr_q < STAT_LIM) ? ST_STAT : ST_ONES;
                    else if (cmd_q == CMD_RD_ALL)
                        state_d = (ptr_q < MEM_LIM) ? ST_MEM : ST_ONES;
                    else
                        state_d = ST_MEM;
                end
                ST_MEM: if (tx_req) begin
                    tx_byte = rd_byte;
                    crc_din = rd_byte;
                    crc_upd = 1'b1;
                    ptr_d   = ptr_q + 16'd1;
                    if (span_end) state_d = ST_DCRC;
                end
                ST_STAT: if (tx_req) begin
                    tx_byte = stat_byte;
                    crc_din = stat_byte;
                    crc_upd = 1'b1;
                    ptr_d   = ptr_q + 16'd1;
                    if (ptr_q == STAT_LAST) state_d = ST_DCRC;
                end
                ST_DCRC: if (tx_req) begin
                    tx_byte = crc_val;
                    crc_clr = 1'b1;
                    state_d = (cmd_q == CMD_RD_PAGED && ptr_q < LEG_LIM) ? ST_MEM : ST_ONES;
                end
                ST_ONES: ;
                ST_WSP_OFS: if (rx_valid) begin
                    ptr_d   = {8'h00, rx_data};
                    state_d = ST_WSP_DAT;
                end
                ST_WSP_DAT: if (rx_valid && ptr_q < SP_LIM) begin
                    sp_we = 1'b1;
                    ptr_d = ptr_q + 16'd1;
                end
                ST_RSP_OFS: if (rx_valid) begin
                    ptr_d   = {8'h00, rx_data};
                    state_d = ST_RSP_DAT;
                end
                ST_RSP_DAT: if (tx_req && ptr_q < SP_LIM) begin
                    tx_byte = sp_rbyte;
                    ptr_d   = ptr_q + 16'd1;
                end
                ST_WST: if (rx_valid) begin
                    ptr_d      = {8'h00, rx_data};
                    prog_start = 1'b1;
                    state_d    = ST_PROG;
                end
                ST_PROG: if (prog_done) begin
                    copy_go = (cmd_q == CMD_COPY_SP);
                    wp_go   = (cmd_q == CMD_WR_STAT);
                    state_d = ST_IGNORE;
                end
                ST_IGNORE: ;
                default: state_d = ST_IGNORE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            cmd_q   <= 8'h00;
            ptr_q   <= 16'h0000;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            ptr_q   <= ptr_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid  <= 1'b0;
            tx_data_q <= 8'hFF;
        end else begin
            tx_valid <= tx_req;
            if (tx_req) tx_data_q <= tx_byte;
        end
    end

    assign tx_data = tx_data_q;

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int PAGES = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             tx_req,
    input logic             tx_valid,
    input logic             busy,
    input logic [PAGES-1:0] wp
);

    assert_tx_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);

    assert_no_stray_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid);

    assert_busy_from_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(rx_valid));

    assert_wp_only_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(wp)) & wp) == '0);

    assert_wp_at_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp) |-> $fell(busy));

endmodule

bind pagemem_cmdseq sq_checker #(.PAGES(PAGES)) u_sq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .tx_req  (tx_req),
    .tx_valid(tx_valid),
    .busy    (busy),
    .wp      (wp_bits)
);

// File: tb/test_pagemem_cmdseq.sv
module test_pagemem_cmdseq;

    localparam int BUSY_N = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    bit done_rpt = 1'b0;

    logic [7:0] m_mem [160];
    logic [7:0] m_sp  [8];
    logic [4:0] m_wp;

    always #4 clk = ~clk;

    pagemem_cmdseq #(.PROG_CYCLES(BUSY_N)) i_pagemem_cmdseq (
        .clk(clk), .rst_n(rst_n), .link_reset(link_reset),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy)
    );

    function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 8'h8C) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] stat_model(input int i);
        if (i == 0) return {3'b111, m_wp};
        if (i == 7) return 8'h00;
        return 8'hFF;
    endfunction

    task automatic report();
        if (!done_rpt) begin
            done_rpt = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic lreset();
        @(negedge clk); link_reset = 1'b1;
        @(negedge clk); link_reset = 1'b0;
    endtask

    task automatic get(input string tag, input logic [7:0] exp);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        if (!tx_valid) begin
            n_chk++; n_err++;
            $display("FAIL R12 (%s): actual tx_valid 0 expected 1", tag);
        end
        chk(tag, tx_data, exp);
    endtask

    // Opens a read command and checks its header CRC (R2).
    task automatic open_read(input logic [7:0] cmd, input logic [7:0] ta1, input logic [7:0] ta2);
        logic [7:0] a1 = ta1, a2 = ta2, c;
        if (cmd != 8'h65) begin a1 = ta1 & 8'h7F; a2 = 8'h00; end
        c = crc_add(crc_add(crc_add(8'h00, cmd), a1), a2);
        lreset();
        send(cmd); send(ta1); send(ta2);
        get("R2 header crc", c);
    endtask

    task automatic wait_busy(input string tag);
        int n = 0;
        chk({tag, " busy raised"}, busy, 1'b1);
        while (busy && n < 1000) begin
            if (n == 5) begin rx_valid = 1'b1; rx_data = 8'h6C; end
            if (n == 6) begin rx_valid = 1'b0; link_reset = 1'b1; end
            if (n == 7) link_reset = 1'b0;
            n++;
            @(negedge clk);
        end
        chk({tag, " busy length"}, n, BUSY_N);
    endtask

    task automatic do_copy(input logic [7:0] ta1, input logic [7:0] ta2);
        int base = {ta2, ta1} & 16'hFFF8;
        lreset();
        send(8'h48); send(ta1); send(ta2);
        wait_busy("R8 copy");
        if (base < 160 && m_wp[base / 32])
            for (int j = 0; j < 8; j++) m_mem[base + j] = m_sp[j];
    endtask

    task automatic fill_sp(input logic [7:0] seed);
        lreset();
        send(8'h6C); send(8'h00);
        for (int j = 0; j < 8; j++) begin
            m_sp[j] = seed + 8'(j * 29);
            send(m_sp[j]);
        end
    endtask

    task automatic t_reset();
        logic [7:0] c = 8'h00;
        chk("R1 busy after reset", busy, 1'b0);
        chk("R1 tx_valid after reset", tx_valid, 1'b0);
        open_read(8'hAA, 8'h00, 8'h00);
        for (int i = 0; i < 8; i++) begin
            get("R1 R11 status byte", stat_model(i));
            c = crc_add(c, stat_model(i));
        end
        get("R11 status crc", c);
        get("R11 ones after crc", 8'hFF);
        open_read(8'h65, 8'h00, 8'h00);
        for (int i = 0; i < 4; i++) get("R1 array reads ones", 8'hFF);
    endtask

    task automatic t_idle_tx();
        lreset();
        get("R12 idle request gives FFh", 8'hFF);
        @(negedge clk);
        chk("R12 no tx_valid without request", tx_valid, 1'b0);
    endtask

    task automatic t_scratch();
        lreset();
        send(8'h6C); send(8'h05);
        for (int j = 0; j < 5; j++) send(8'hA1 + 8'(j));
        for (int j = 0; j < 3; j++) m_sp[5 + j] = 8'hA1 + 8'(j);
        lreset();
        send(8'h69); send(8'h00);
        for (int j = 0; j < 8; j++) get("R6 R7 scratchpad byte", m_sp[j]);
        get("R7 ones past offset 07h", 8'hFF);
        get("R7 ones past offset 07h", 8'hFF);
    endtask

    task automatic t_copy();
        fill_sp(8'h10); do_copy(8'h27, 8'h00);
        fill_sp(8'h33); do_copy(8'h63, 8'h00);
        fill_sp(8'h5A); do_copy(8'h9B, 8'h00);
        fill_sp(8'h07); do_copy(8'h0C, 8'h00);
        open_read(8'h65, 8'h20, 8'h00);
        for (int j = 0; j < 8; j++) get("R8 copied byte", m_mem[8'h20 + j]);
    endtask

    task automatic t_legacy();
        logic [7:0] c = 8'h00;
        open_read(8'hF0, 8'h8C, 8'h0F);
        for (int a = 8'h0C; a < 128; a++) begin
            get("R3 legacy data", m_mem[a]);
            c = crc_add(c, m_mem[a]);
        end
        get("R3 legacy data crc", c);
        get("R3 ones after crc", 8'hFF);
    endtask

    task automatic t_paged();
        logic [7:0] c = 8'h00;
        open_read(8'hC3, 8'h3E, 8'h00);
        for (int a = 8'h3E; a < 128; a++) begin
            get("R4 paged data", m_mem[a]);
            c = crc_add(c, m_mem[a]);
            if ((a % 32) == 31) begin
                get("R4 page crc", c);
                c = 8'h00;
            end
        end
        get("R4 ones after page 3 crc", 8'hFF);
    endtask

    task automatic t_readall();
        logic [7:0] c = 8'h00;
        open_read(8'h65, 8'h98, 8'h00);
        for (int a = 8'h98; a < 160; a++) begin
            get("R5 read-all data", m_mem[a]);
            c = crc_add(c, m_mem[a]);
        end
        get("R5 read-all crc", c);
        get("R5 ones after crc", 8'hFF);
        open_read(8'h65, 8'hA0, 8'h00);
        get("R5 reserved start gives ones", 8'hFF);
        get("R5 reserved start gives ones", 8'hFF);
    endtask

    task automatic t_protect();
        logic [7:0] c = 8'h00;
        lreset(); send(8'h55); send(8'hF7);
        wait_busy("R9 status write");
        m_wp = m_wp & 5'b10111;
        lreset(); send(8'h55); send(8'hFF);
        wait_busy("R9 status write ones");
        open_read(8'hAA, 8'h80, 8'h00);
        get("R9 protect byte after clear", 8'hF7);
        fill_sp(8'hC1); do_copy(8'h60, 8'h00);
        fill_sp(8'hD2); do_copy(8'hA8, 8'h00);
        open_read(8'h65, 8'h60, 8'h00);
        for (int j = 0; j < 8; j++) get("R10 protected page unchanged", m_mem[8'h60 + j]);
        open_read(8'hAA, 8'h85, 8'h00);
        for (int i = 5; i < 8; i++) begin
            get("R11 status from masked 05h", stat_model(i));
            c = crc_add(c, stat_model(i));
        end
        get("R11 status crc", c);
        open_read(8'hAA, 8'h09, 8'h00);
        get("R11 start past 07h gives ones", 8'hFF);
    endtask

    task automatic t_abandon();
        lreset();
        send(8'h6C); send(8'h00);
        lreset();
        send(8'hAB);
        send(8'h6C); send(8'h00); send(8'hEE);
        lreset();
        send(8'h69); send(8'h00);
        get("R13 unknown command ignored", m_sp[0]);
    endtask

    initial begin
        for (int i = 0; i < 160; i++) m_mem[i] = 8'hFF;
        for (int j = 0; j < 8; j++) m_sp[j] = 8'hFF;
        m_wp = 5'b11111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_tx();
        t_scratch();
        t_copy();
        t_legacy();
        t_paged();
        t_readall();
        t_protect();
        t_abandon();
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule